// File: doc/BRIEF.md
# Flow Control Frame Request Scheduler

This block decides when a link transmitter must emit an XON or an XOFF flow control frame for each of up to eight priority queues. For every queue it keeps a paused/running state, turns request inputs into state changes, and while a pause is still being asked for it sends the XOFF again after a programmed number of pause-quantum ticks. One tick stands for 512 bit times.

Requests arrive in one of two global modes. In level mode a single register bit per queue asks for a pause while it is 1. In coded mode each queue reads a two-bit code, either from a pair of register bits or from a pair of input pins, as chosen per queue. Pending frames from all queues meet in a fixed-priority arbiter. The arbiter hands one frame descriptor at a time to a downstream frame builder over a valid/ready handshake. The descriptor holds the queue index, XON or XOFF, the quanta and the frame format.

The configuration inputs come from a register bank outside this block, which holds their reset values: enables all ones, level mode, pin sources, quanta and hold 0xFFFF, queue-0 format priority-based.

Top module: `fc_req_sched`

## Requirements
- R1: While a queue's enable bit is 0 the queue ignores its requests: its paused state does not change, its refresh counter stops, it drops any frame not yet handed over, and it produces no frame.
- R2: In level mode (mode input 0) a queue reads bit i of the low register request field. A 1 while running sends one XOFF and pauses the queue. A 0 while paused sends one XON and resumes it. The pin inputs and the high register field have no effect in this mode.
- R3: In coded mode (mode input 1) the code for queue i is {high bit i, low bit i}. It comes from the pins when source bit i is 0 and from the register fields when source bit i is 1.
- R4: Code 2'b10 requests XOFF and code 2'b01 requests XON. An XON code while running, and the codes 2'b00 and 2'b11, send no frame and keep the state.
- R5: After an XOFF of a queue is handed over, and while XOFF is still actively requested, another XOFF follows once that queue's hold value in ticks has elapsed. It does not come earlier.
- R6: An XOFF frame carries its queue's 16-bit quanta value. An XON frame carries quanta 0.
- R7: The format output is 1 (priority-based) for every queue except queue 0. For queue 0 it equals the format select input (0 = classic pause).
- R8: When several queues have frames pending, the lowest queue index is offered first, and one frame is offered at a time.
- R9: While the valid output is 1 and ready is 0, the valid output and every descriptor field stay unchanged. A frame is consumed on a cycle where valid and ready are both 1.
- R10: After reset the valid output is 0 and every queue is in the running (XON) state, so the first stimulus that sends a frame sends an XOFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse per 512 bit times |
| cfg_enable_i | input | NUM_Q | Per-queue enable |
| cfg_coded_mode_i | input | 1 | 0 = level mode, 1 = coded mode |
| cfg_src_reg_i | input | NUM_Q | Coded-mode source, 1 = register fields |
| reg_req_lo_i | input | NUM_Q | Register request field, lower bit |
| reg_req_hi_i | input | NUM_Q | Register request field, upper bit |
| pin_req_lo_i | input | NUM_Q | Pin request, lower bit |
| pin_req_hi_i | input | NUM_Q | Pin request, upper bit |
| cfg_quanta_i | input | NUM_Q*QUANTA_W | Per-queue quanta, queue i at bits i*QUANTA_W |
| cfg_hold_i | input | NUM_Q*HOLD_W | Per-queue XOFF refresh spacing in ticks |
| cfg_q0_pfc_i | input | 1 | Queue-0 format, 1 = priority-based |
| frm_valid_o | output | 1 | Frame descriptor valid |
| frm_ready_i | input | 1 | Frame builder ready |
| frm_queue_o | output | QIDX_W | Queue index of the frame |
| frm_xoff_o | output | 1 | 1 = XOFF, 0 = XON |
| frm_quanta_o | output | QUANTA_W | Quanta carried by the frame |
| frm_pfc_o | output | 1 | 1 = priority-based format, 0 = classic pause |

## Verification
The bench builds the block with its defaults of eight queues and 16-bit quanta and hold values. Queue 7 therefore takes part, and the index and format paths carry their full width. The hold value is an input, so the bench programs a hold of three ticks on one queue. This makes the exact refresh spacing observable within a few cycles, while every other queue keeps 0xFFFF and cannot refresh during the run. Distinct quanta per queue expose any wrong selection in the descriptor multiplexer.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
   typedef enum logic [1:0] {
      CODE_HOLD0 = 2'b00,
      CODE_XON   = 2'b01,
      CODE_XOFF  = 2'b10,
      CODE_HOLD1 = 2'b11
   } fc_code_e;

   typedef struct packed {
      logic act_xoff;
      logic act_xon;
   } fc_intent_t;

   function automatic fc_intent_t decode_code(input logic [1:0] code);
      fc_intent_t r;
      r.act_xoff = (code == CODE_XOFF);
      r.act_xon  = (code == CODE_XON);
      return r;
   endfunction
endpackage

// File: rtl/fcs_req_decode.sv
module fcs_req_decode
   import fcs_pkg::*;
(
   input  logic       coded_mode_i,
   input  logic       src_reg_i,
   input  logic       reg_lo_i,
   input  logic       reg_hi_i,
   input  logic       pin_lo_i,
   input  logic       pin_hi_i,
   output fc_intent_t intent_o
);
   logic [1:0] code;

   always_comb begin
      code = src_reg_i ? {reg_hi_i, reg_lo_i} : {pin_hi_i, pin_lo_i};
      if (coded_mode_i) begin
         intent_o = decode_code(code);
      end else begin
         intent_o.act_xoff = reg_lo_i;
         intent_o.act_xon  = ~reg_lo_i;
      end
   end
endmodule

// File: rtl/fcs_queue.sv
module fcs_queue
   import fcs_pkg::*;
#(
   parameter int HOLD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              tick_i,
   input  logic              coded_mode_i,
   input  fc_intent_t        intent_i,
   input  logic [HOLD_W-1:0] hold_i,
   input  logic              grant_i,
   output logic              pend_o,
   output logic              pend_xoff_o
);
   logic              paused_q;
   logic              pend_q;
   logic              kind_xoff_q;
   logic [HOLD_W-1:0] cnt_q;
   logic              want_xoff;
   logic              want_xon;

   assign want_xoff = en_i & intent_i.act_xoff;
   assign want_xon  = en_i & intent_i.act_xon;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         paused_q    <= 1'b0;
         pend_q      <= 1'b0;
         kind_xoff_q <= 1'b0;
         cnt_q       <= '0;
      end else if (!en_i) begin
         pend_q <= 1'b0;
      end else begin
         if (grant_i) begin
            pend_q <= 1'b0;
            if (kind_xoff_q) cnt_q <= hold_i;
         end
         if (want_xoff && paused_q && !pend_q) begin
            if (cnt_q == '0) begin
               pend_q      <= 1'b1;
               kind_xoff_q <= 1'b1;
            end else if (tick_i) begin
               cnt_q <= cnt_q - 1'b1;
            end
         end
         if (want_xoff && !paused_q) begin
            paused_q    <= 1'b1;
            pend_q      <= 1'b1;
            kind_xoff_q <= 1'b1;
            cnt_q       <= hold_i;
         end else if (want_xon && paused_q) begin
            paused_q    <= 1'b0;
            pend_q      <= 1'b1;
            kind_xoff_q <= 1'b0;
         end
      end
   end

   assign pend_o      = pend_q & en_i;
   assign pend_xoff_o = kind_xoff_q;

   AST_FROZEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> $stable(paused_q)); // R1
   AST_HOLD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && coded_mode_i && !intent_i.act_xoff && !intent_i.act_xon) |=> $stable(paused_q)); // R4
   AST_NO_XON_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && want_xon && !paused_q && !pend_q) |=> !pend_q); // R4
endmodule

// File: rtl/fcs_arbiter.sv
module fcs_arbiter #(
   parameter int NUM_Q    = 8,
   parameter int QUANTA_W = 16,
   parameter int QIDX_W   = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_Q-1:0]          req_i,
   input  logic [NUM_Q-1:0]          kind_xoff_i,
   input  logic [NUM_Q*QUANTA_W-1:0] quanta_i,
   input  logic                      q0_pfc_i,
   output logic [NUM_Q-1:0]          grant_o,
   output logic                      frm_valid_o,
   input  logic                      frm_ready_i,
   output logic [QIDX_W-1:0]         frm_queue_o,
   output logic                      frm_xoff_o,
   output logic [QUANTA_W-1:0]       frm_quanta_o,
   output logic                      frm_pfc_o
);
   logic [QIDX_W-1:0] sel;
   logic              load;
   logic              any_req;

   always_comb begin
      sel = '0;
      for (int i = NUM_Q - 1; i >= 0; i--) begin
         if (req_i[i]) sel = QIDX_W'(i);
      end
   end

   assign any_req = |req_i;
   assign load    = (!frm_valid_o || frm_ready_i) && any_req;

   always_comb begin
      grant_o = '0;
      if (load) grant_o[sel] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frm_valid_o  <= 1'b0;
         frm_queue_o  <= '0;
         frm_xoff_o   <= 1'b0;
         frm_quanta_o <= '0;
         frm_pfc_o    <= 1'b0;
      end else if (!frm_valid_o || frm_ready_i) begin
         frm_valid_o <= any_req;
         if (any_req) begin
            frm_queue_o  <= sel;
            frm_xoff_o   <= kind_xoff_i[sel];
            frm_quanta_o <= kind_xoff_i[sel] ? quanta_i[sel*QUANTA_W +: QUANTA_W] : '0;
            frm_pfc_o    <= (sel != '0) | q0_pfc_i;
         end
      end
   end

   AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o)); // R8
   AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_o != '0) |-> ((req_i & (grant_o - 1'b1)) == '0)); // R8
   AST_STALL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_valid_o && !frm_ready_i) |=> (frm_valid_o && $stable(frm_queue_o)
         && $stable(frm_xoff_o) && $stable(frm_quanta_o) && $stable(frm_pfc_o))); // R9
endmodule

// File: rtl/fc_req_sched.sv
module fc_req_sched
   import fcs_pkg::*;
#(
   parameter int NUM_Q    = 8,
   parameter int QUANTA_W = 16,
   parameter int HOLD_W   = 16,
   localparam int QIDX_W  = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      tick_i,
   input  logic [NUM_Q-1:0]          cfg_enable_i,
   input  logic                      cfg_coded_mode_i,
   input  logic [NUM_Q-1:0]          cfg_src_reg_i,
   input  logic [NUM_Q-1:0]          reg_req_lo_i,
   input  logic [NUM_Q-1:0]          reg_req_hi_i,
   input  logic [NUM_Q-1:0]          pin_req_lo_i,
   input  logic [NUM_Q-1:0]          pin_req_hi_i,
   input  logic [NUM_Q*QUANTA_W-1:0] cfg_quanta_i,
   input  logic [NUM_Q*HOLD_W-1:0]   cfg_hold_i,
   input  logic                      cfg_q0_pfc_i,
   output logic                      frm_valid_o,
   input  logic                      frm_ready_i,
   output logic [QIDX_W-1:0]         frm_queue_o,
   output logic                      frm_xoff_o,
   output logic [QUANTA_W-1:0]       frm_quanta_o,
   output logic                      frm_pfc_o
);
   if (NUM_Q < 1 || NUM_Q > 8) begin : g_bad_nq
      $error("NUM_Q must lie in 1..8");
   end
   if (QUANTA_W < 1 || HOLD_W < 1) begin : g_bad_w
      $error("QUANTA_W and HOLD_W must be positive");
   end

   logic [NUM_Q-1:0] pend;
   logic [NUM_Q-1:0] kind_xoff;
   logic [NUM_Q-1:0] grant;

   for (genvar q = 0; q < NUM_Q; q++) begin : g_q
      fc_intent_t intent;

      fcs_req_decode i_dec (
         .coded_mode_i (cfg_coded_mode_i),
         .src_reg_i    (cfg_src_reg_i[q]),
         .reg_lo_i     (reg_req_lo_i[q]),
         .reg_hi_i     (reg_req_hi_i[q]),
         .pin_lo_i     (pin_req_lo_i[q]),
         .pin_hi_i     (pin_req_hi_i[q]),
         .intent_o     (intent)
      );

      fcs_queue #(.HOLD_W(HOLD_W)) i_queue (
         .clk          (clk),
         .rst_n        (rst_n),
         .en_i         (cfg_enable_i[q]),
         .tick_i       (tick_i),
         .coded_mode_i (cfg_coded_mode_i),
         .intent_i     (intent),
         .hold_i       (cfg_hold_i[q*HOLD_W +: HOLD_W]),
         .grant_i      (grant[q]),
         .pend_o       (pend[q]),
         .pend_xoff_o  (kind_xoff[q])
      );
   end

   fcs_arbiter #(
      .NUM_Q    (NUM_Q),
      .QUANTA_W (QUANTA_W),
      .QIDX_W   (QIDX_W)
   ) i_arb (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_i        (pend),
      .kind_xoff_i  (kind_xoff),
      .quanta_i     (cfg_quanta_i),
      .q0_pfc_i     (cfg_q0_pfc_i),
      .grant_o      (grant),
      .frm_valid_o  (frm_valid_o),
      .frm_ready_i  (frm_ready_i),
      .frm_queue_o  (frm_queue_o),
      .frm_xoff_o   (frm_xoff_o),
      .frm_quanta_o (frm_quanta_o),
      .frm_pfc_o    (frm_pfc_o)
   );

   AST_GRANT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      ((grant & ~pend) == '0)); // R8
   AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      ((grant & ~cfg_enable_i) == '0)); // R1
endmodule

// File: tb/test_fc_req_sched.sv
module test_fc_req_sched;
   localparam int NQ = 8;
   localparam int QW = 16;
   localparam int HW = 16;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            tick = 1'b0;
   logic [NQ-1:0]   en = '1;
   logic            coded = 1'b0;
   logic [NQ-1:0]   src = '0;
   logic [NQ-1:0]   rlo = '0, rhi = '0, plo = '0, phi = '0;
   logic [NQ*QW-1:0] quanta;
   logic [NQ*HW-1:0] hold;
   logic            q0pfc = 1'b1;
   logic            valid, ready = 1'b1;
   logic [2:0]      fq;
   logic            fxoff, fpfc;
   logic [QW-1:0]   fquanta;

   int errors = 0;
   int checks = 0;

   always #4 clk = ~clk;

   fc_req_sched i_fc_req_sched (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .cfg_enable_i(en),
      .cfg_coded_mode_i(coded), .cfg_src_reg_i(src),
      .reg_req_lo_i(rlo), .reg_req_hi_i(rhi), .pin_req_lo_i(plo), .pin_req_hi_i(phi),
      .cfg_quanta_i(quanta), .cfg_hold_i(hold), .cfg_q0_pfc_i(q0pfc),
      .frm_valid_o(valid), .frm_ready_i(ready), .frm_queue_o(fq),
      .frm_xoff_o(fxoff), .frm_quanta_o(fquanta), .frm_pfc_o(fpfc)
   );

   function automatic logic [QW-1:0] qv(input int q);
      return QW'(16'h1100 + q * 16'h0111);
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic expect_frame(input int q, input bit xoff, input string req);
      bit got = 0;
      for (int n = 0; n < 20 && !got; n++) begin
         @(negedge clk);
         if (valid) got = 1;
      end
      chk(got, req, "frame valid", int'(got), 1);
      if (got) begin
         logic [QW-1:0] eq = xoff ? qv(q) : '0;
         bit epfc = (q != 0) || q0pfc;
         chk(fq == 3'(q), req, "queue", int'(fq), q);
         chk(fxoff == xoff, req, "xoff", int'(fxoff), int'(xoff));
         chk(fquanta == eq, req, "quanta", int'(fquanta), int'(eq));
         chk(fpfc == epfc, req, "format", int'(fpfc), int'(epfc));
      end
   endtask

   task automatic expect_none(input int n, input string req);
      bit seen = 0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (valid) seen = 1;
      end
      chk(!seen, req, "no frame", int'(seen), 0);
   endtask

   task automatic pulse_tick();
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(!valid, "R10", "valid after reset", int'(valid), 0);
      @(negedge clk); rlo[7] = 1'b1;
      expect_frame(7, 1, "R10");
      @(negedge clk); rlo[7] = 1'b0;
      expect_frame(7, 0, "R10");
   endtask

   task automatic t_level_mode();
      @(negedge clk); rlo[2] = 1'b1;
      expect_frame(2, 1, "R2");
      expect_none(6, "R2");
      @(negedge clk); rlo[2] = 1'b0;
      expect_frame(2, 0, "R6");
      @(negedge clk); phi[3] = 1'b1; rhi[3] = 1'b1;
      expect_none(10, "R2");
      @(negedge clk); phi[3] = 1'b0; rhi[3] = 1'b0;
   endtask

   task automatic t_refresh();
      @(negedge clk); rlo[1] = 1'b1;
      expect_frame(1, 1, "R5");
      pulse_tick(); pulse_tick();
      expect_none(5, "R5");
      pulse_tick();
      expect_frame(1, 1, "R5");
      @(negedge clk); rlo[1] = 1'b0;
      expect_frame(1, 0, "R5");
   endtask

   task automatic t_enable();
      @(negedge clk); en[4] = 1'b0; rlo[4] = 1'b1;
      expect_none(10, "R1");
      @(negedge clk); en[4] = 1'b1; rlo[4] = 1'b0;
      expect_none(10, "R1");
      @(negedge clk); rlo[4] = 1'b1;
      expect_frame(4, 1, "R1");
      @(negedge clk); rlo[4] = 1'b0;
      expect_frame(4, 0, "R1");
   endtask

   task automatic t_priority();
      @(negedge clk); ready = 1'b0; q0pfc = 1'b0; rlo[6] = 1'b1; rlo[0] = 1'b1;
      repeat (3) @(negedge clk);
      chk(valid && fq == 3'd0, "R8", "lowest first", int'(fq), 0);
      chk(fpfc == 1'b0, "R7", "queue0 classic", int'(fpfc), 0);
      repeat (4) @(negedge clk);
      chk(valid && fq == 3'd0 && fxoff, "R9", "held while stalled", int'(fq), 0);
      ready = 1'b1;
      @(negedge clk);
      chk(valid && fq == 3'd6, "R8", "next queue", int'(fq), 6);
      chk(fpfc == 1'b1, "R7", "queue6 pfc", int'(fpfc), 1);
      @(negedge clk); rlo[6] = 1'b0; rlo[0] = 1'b0;
      expect_frame(0, 0, "R8");
      expect_frame(6, 0, "R8");
      q0pfc = 1'b1;
   endtask

   task automatic t_coded_mode();
      @(negedge clk); coded = 1'b1; src[5] = 1'b1;
      expect_none(8, "R4");
      @(negedge clk); phi[3] = 1'b1;
      expect_frame(3, 1, "R3");
      @(negedge clk); plo[3] = 1'b1;
      expect_none(10, "R4");
      @(negedge clk); phi[3] = 1'b0;
      expect_frame(3, 0, "R4");
      expect_none(8, "R4");
      @(negedge clk); plo[3] = 1'b0;
      expect_none(6, "R4");
      @(negedge clk); phi[5] = 1'b1;
      expect_none(8, "R3");
      @(negedge clk); rhi[5] = 1'b1;
      expect_frame(5, 1, "R3");
      @(negedge clk); rhi[5] = 1'b0; rlo[5] = 1'b1;
      expect_frame(5, 0, "R3");
      @(negedge clk); rlo[5] = 1'b0; phi[5] = 1'b0;
      expect_none(6, "R4");
   endtask

   initial begin
      for (int i = 0; i < NQ; i++) begin
         quanta[i*QW +: QW] = qv(i);
         hold[i*HW +: HW] = (i == 1) ? HW'(3) : '1;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_level_mode();
      t_refresh();
      t_enable();
      t_priority();
      t_coded_mode();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule